// File: doc/BRIEF.md
# Cartridge Freeze-Trigger Controller

This block is the control slave of a memory-expansion cartridge that can halt a running host CPU. It watches every CPU byte access and decides when to assert a one-cycle non-maskable interrupt request, called a freeze. A freeze has four possible sources: a rising edge on the freeze button, the first write to chip memory after a system reset, an armed byte read of the probe address at `0xBFE001`, and an armed byte write to the probe address at `0xBFD100`. The controller stores a 2-bit code that records which source fired. It also decides whether the cartridge ROM/RAM window is visible on the bus.

Software on the cartridge talks to the controller through a few byte locations at the bottom of the ROM window. It reads the freeze cause from the status byte. Writing the control byte arms the two probe triggers, clears the cause and hides the cartridge in one access. A write to the overlay byte drops the chip-RAM overlay, which gives the host back its original level-7 vector. While the cartridge is hidden, its window behaves like empty address space. A later armed probe match makes the cartridge visible again.

Top module: `fcart_freeze_ctrl`

## Requirements
- R1: Reset leaves the cause at 3 (reset), the cartridge hidden, the overlay off and the interrupt request low.
- R2: After reset, only a write below the chip-memory limit (`0x200000`) starts a freeze. Accesses elsewhere do not. This freeze keeps the cause at 3, pulses the interrupt request in the cycle after the write and makes the cartridge visible.
- R3: While visible, a read at window offset 1 or its mirror at offset 3 returns the bus value with bits 1:0 replaced by the cause code. A read at offset 0 or 2 returns the bus value. A read at offset 4 or above returns the array data.
- R4: A visible write at window offset 1 or 3 loads the read-probe arm from data bit 1 and the write-probe arm from data bit 0. It clears the cause to 0, hides the cartridge and ends the freeze in service.
- R5: With the read probe armed and no freeze in service, a byte read of `0xBFE001` sets the cause to 1, pulses the interrupt request and makes the cartridge visible. A write to that address has no effect.
- R6: With the write probe armed and no freeze in service, a byte write to `0xBFD100` sets the cause to 2, pulses the interrupt request and makes the cartridge visible. A read of that address has no effect.
- R7: A probe whose arm bit is clear never causes a freeze.
- R8: Outside the post-reset wait, a rising edge of the freeze button causes a freeze with cause 0 when no freeze is in service. The edge acts after a two-stage synchroniser, so the request appears three cycles after the button rises.
- R9: The interrupt request is high for exactly one cycle per freeze. No new freeze from any source can start until the control byte is written.
- R10: While hidden, reads anywhere in the window return the bus value. The window strobes stay low, and writes to the register bytes have no effect.
- R11: Every freeze turns the overlay on. A visible write at window offset 6 or 7 turns it off in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| acc_valid | input | 1 | A CPU byte access is on the bus this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 24 | Byte address of the access |
| acc_wdata | input | 8 | Write data |
| bus_float | input | 8 | Value the bus holds when no slave drives it |
| win_rdata | input | 8 | Read data from the external ROM/RAM arrays |
| freeze_btn | input | 1 | Asynchronous freeze button level |
| rd_data | output | 8 | Read data the CPU sees |
| win_rd_en | output | 1 | Read strobe to the ROM/RAM arrays |
| win_wr_en | output | 1 | Write strobe to the ROM/RAM arrays |
| nmi_req | output | 1 | One-cycle freeze interrupt request |
| cart_visible | output | 1 | Cartridge window is mapped |
| overlay_on | output | 1 | Chip-RAM overlay is active |

## Verification
The assertions hold on every cycle for the properties that relate ports over time:
- the request lasts a single cycle and never coincides with a hidden cartridge;
- no request follows a freeze that is still in service;
- hidden reads return the bus value and both strobes stay low;
- a visible control write hides the cartridge;
- an overlay write clears the overlay unless a freeze fires in the same cycle.

The bench scenarios cover what depends on history. These are the cause code reported after each source fires, the wrong-direction and unarmed probe accesses, writes that are dropped while hidden, and the button synchroniser latency.

// File: rtl/fcart_pkg.sv
package fcart_pkg;

    typedef enum logic [1:0] {
        CAUSE_BUTTON   = 2'd0,
        CAUSE_RD_PROBE = 2'd1,
        CAUSE_WR_PROBE = 2'd2,
        CAUSE_RESET    = 2'd3
    } cause_e;

    // Decoded view of the current bus access, already qualified by acc_valid.
    typedef struct packed {
        logic in_window;  // ROM or RAM window
        logic reg_any;    // ROM offsets 0..7
        logic reg_stat;   // offset 1 or 3, read
        logic reg_low;    // offset 0 or 2, read
        logic ctrl_wr;    // offset 1 or 3, write
        logic ovl_wr;     // offset 6 or 7, write
        logic chip_wr;    // write below chip limit
        logic rd_probe;   // read of read-probe address
        logic wr_probe;   // write of write-probe address
        logic is_rd;
        logic is_wr;
    } acc_dec_t;

    typedef struct packed {
        logic on_read;
        logic on_write;
    } arm_t;

    localparam int unsigned REG_BYTES = 8;
    localparam int unsigned DATA_W    = 8;

    function automatic arm_t arm_from_byte(input logic [DATA_W-1:0] b);
        arm_t a;
        a.on_read  = b[1];
        a.on_write = b[0];
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input logic [DATA_W-1:0] flt,
                                                      input cause_e c);
        return {flt[DATA_W-1:2], c};
    endfunction

endpackage

// File: rtl/fcart_decode.sv
module fcart_decode
    import fcart_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned ROM_BASE = 32'h0040_0000,
    parameter int unsigned ROM_SIZE = 32'h0004_0000,
    parameter int unsigned RAM_BASE = 32'h0044_0000,
    parameter int unsigned RAM_SIZE = 32'h0001_0000,
    parameter int unsigned CHIP_TOP = 32'h0020_0000,
    parameter int unsigned RD_PROBE = 32'h00BF_E001,
    parameter int unsigned WR_PROBE = 32'h00BF_D100
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output acc_dec_t          dec
);
    localparam logic [ADDR_W-1:0] ROM_B = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] ROM_S = ADDR_W'(ROM_SIZE);
    localparam logic [ADDR_W-1:0] RAM_B = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] RAM_S = ADDR_W'(RAM_SIZE);
    localparam logic [ADDR_W-1:0] CHIP  = ADDR_W'(CHIP_TOP);
    localparam logic [ADDR_W-1:0] RDP   = ADDR_W'(RD_PROBE);
    localparam logic [ADDR_W-1:0] WRP   = ADDR_W'(WR_PROBE);
    localparam logic [ADDR_W-1:0] REGN  = ADDR_W'(REG_BYTES);

    logic [ADDR_W-1:0] rom_off, ram_off;
    logic              in_rom, in_ram, is_reg;
    logic [2:0]        roff;

    always_comb begin
        rom_off = addr - ROM_B;
        ram_off = addr - RAM_B;
        in_rom  = rom_off < ROM_S;
        in_ram  = ram_off < RAM_S;
        is_reg  = in_rom && (rom_off < REGN);
        roff    = rom_off[2:0];

        dec.is_rd     = valid && !write;
        dec.is_wr     = valid && write;
        dec.in_window = valid && (in_rom || in_ram);
        dec.reg_any   = valid && is_reg;
        dec.reg_stat  = dec.is_rd && is_reg && (roff == 3'd1 || roff == 3'd3);
        dec.reg_low   = dec.is_rd && is_reg && (roff == 3'd0 || roff == 3'd2);
        dec.ctrl_wr   = dec.is_wr && is_reg && (roff == 3'd1 || roff == 3'd3);
        dec.ovl_wr    = dec.is_wr && is_reg && (roff == 3'd6 || roff == 3'd7);
        dec.chip_wr   = dec.is_wr && (addr < CHIP);
        dec.rd_probe  = dec.is_rd && (addr == RDP);
        dec.wr_probe  = dec.is_wr && (addr == WRP);
    end

endmodule

// File: rtl/fcart_trigger.sv
module fcart_trigger
    import fcart_pkg::*;
#(
    parameter int unsigned BTN_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_dec_t          dec,
    input  logic [DATA_W-1:0] wdata,
    input  logic              btn_async,
    output cause_e            cause,
    output logic              visible,
    output logic              busy,
    output logic              overlay,
    output logic              nmi
);
    // Button synchroniser, depth chosen by parameter.
    logic [BTN_SYNC-1:0] sync_q;
    logic                btn_prev_q;
    logic                btn_edge;

    genvar g;
    generate
        for (g = 0; g < BTN_SYNC; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= btn_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign btn_edge = sync_q[BTN_SYNC-1] && !btn_prev_q;

    arm_t   arm_q;
    cause_e cause_q;
    logic   hidden_q, busy_q, wait_chip_q, ovl_q, nmi_q;

    logic   ctrl_hit, ovl_hit, fire;
    cause_e fire_cause;

    always_comb begin
        ctrl_hit   = dec.ctrl_wr && !hidden_q;
        ovl_hit    = dec.ovl_wr && !hidden_q;
        fire       = 1'b0;
        fire_cause = CAUSE_RESET;
        if (wait_chip_q) begin
            fire = dec.chip_wr;
        end else if (!busy_q && !ctrl_hit) begin
            if (btn_edge) begin
                fire       = 1'b1;
                fire_cause = CAUSE_BUTTON;
            end else if (dec.rd_probe && arm_q.on_read) begin
                fire       = 1'b1;
                fire_cause = CAUSE_RD_PROBE;
            end else if (dec.wr_probe && arm_q.on_write) begin
                fire       = 1'b1;
                fire_cause = CAUSE_WR_PROBE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q       <= '0;
            cause_q     <= CAUSE_RESET;
            hidden_q    <= 1'b1;
            busy_q      <= 1'b0;
            wait_chip_q <= 1'b1;
            ovl_q       <= 1'b0;
            nmi_q       <= 1'b0;
            btn_prev_q  <= 1'b0;
        end else begin
            btn_prev_q <= sync_q[BTN_SYNC-1];
            nmi_q      <= fire;
            if (ctrl_hit) begin
                arm_q    <= arm_from_byte(wdata);
                cause_q  <= CAUSE_BUTTON;
                hidden_q <= 1'b1;
                busy_q   <= 1'b0;
            end
            if (ovl_hit) ovl_q <= 1'b0;
            if (fire) begin
                cause_q     <= fire_cause;
                hidden_q    <= 1'b0;
                busy_q      <= 1'b1;
                wait_chip_q <= 1'b0;
                ovl_q       <= 1'b1;
            end
        end
    end

    assign cause   = cause_q;
    assign visible = !hidden_q;
    assign busy    = busy_q;
    assign overlay = ovl_q;
    assign nmi     = nmi_q;

endmodule

// File: rtl/fcart_rdmux.sv
module fcart_rdmux
    import fcart_pkg::*;
(
    input  acc_dec_t          dec,
    input  logic              visible,
    input  cause_e            cause,
    input  logic [DATA_W-1:0] bus_float,
    input  logic [DATA_W-1:0] win_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              win_rd_en,
    output logic              win_wr_en
);
    logic mapped;

    always_comb begin
        mapped    = dec.in_window && visible;
        win_rd_en = mapped && dec.is_rd && !dec.reg_stat && !dec.reg_low;
        win_wr_en = mapped && dec.is_wr && !dec.reg_any;
        if (!mapped)           rd_data = bus_float;
        else if (dec.reg_stat) rd_data = status_byte(bus_float, cause);
        else if (dec.reg_low)  rd_data = bus_float;
        else                   rd_data = win_rdata;
    end

endmodule

// File: rtl/fcart_freeze_ctrl.sv
module fcart_freeze_ctrl
    import fcart_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned ROM_BASE = 32'h0040_0000,
    parameter int unsigned ROM_SIZE = 32'h0004_0000,
    parameter int unsigned RAM_BASE = 32'h0044_0000,
    parameter int unsigned RAM_SIZE = 32'h0001_0000,
    parameter int unsigned CHIP_TOP = 32'h0020_0000,
    parameter int unsigned RD_PROBE = 32'h00BF_E001,
    parameter int unsigned WR_PROBE = 32'h00BF_D100,
    parameter int unsigned BTN_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    input  logic [7:0]        bus_float,
    input  logic [7:0]        win_rdata,
    input  logic              freeze_btn,
    output logic [7:0]        rd_data,
    output logic              win_rd_en,
    output logic              win_wr_en,
    output logic              nmi_req,
    output logic              cart_visible,
    output logic              overlay_on
);
    acc_dec_t dec;
    cause_e   cause;
    logic     busy;

    fcart_decode #(
        .ADDR_W  (ADDR_W),
        .ROM_BASE(ROM_BASE),
        .ROM_SIZE(ROM_SIZE),
        .RAM_BASE(RAM_BASE),
        .RAM_SIZE(RAM_SIZE),
        .CHIP_TOP(CHIP_TOP),
        .RD_PROBE(RD_PROBE),
        .WR_PROBE(WR_PROBE)
    ) u_decode (
        .valid(acc_valid),
        .write(acc_write),
        .addr (acc_addr),
        .dec  (dec)
    );

    fcart_trigger #(
        .BTN_SYNC(BTN_SYNC)
    ) u_trig (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .wdata    (acc_wdata),
        .btn_async(freeze_btn),
        .cause    (cause),
        .visible  (cart_visible),
        .busy     (busy),
        .overlay  (overlay_on),
        .nmi      (nmi_req)
    );

    fcart_rdmux u_rdmux (
        .dec      (dec),
        .visible  (cart_visible),
        .cause    (cause),
        .bus_float(bus_float),
        .win_rdata(win_rdata),
        .rd_data  (rd_data),
        .win_rd_en(win_rd_en),
        .win_wr_en(win_wr_en)
    );

endmodule

// File: rtl/fcart_freeze_sva.sv
module fcart_freeze_sva #(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned ROM_BASE = 32'h0040_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        bus_float,
    input logic [7:0]        rd_data,
    input logic              win_rd_en,
    input logic              win_wr_en,
    input logic              nmi_req,
    input logic              cart_visible,
    input logic              overlay_on,
    input logic              busy
);
    logic ctrl_acc, ovl_acc;
    assign ctrl_acc = acc_valid && acc_write &&
                      (acc_addr == ADDR_W'(ROM_BASE + 1) || acc_addr == ADDR_W'(ROM_BASE + 3));
    assign ovl_acc  = acc_valid && acc_write &&
                      (acc_addr == ADDR_W'(ROM_BASE + 6) || acc_addr == ADDR_W'(ROM_BASE + 7));

    p_nmi_single_r9: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);

    p_no_refire_r9: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> !$past(busy));

    p_nmi_shows_cart_r5: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> cart_visible);

    p_ctrl_hides_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_acc && cart_visible) |=> !cart_visible);

    p_hidden_float_r10: assert property (@(posedge clk) disable iff (rst)
        (!cart_visible && acc_valid && !acc_write) |-> (rd_data == bus_float));

    p_hidden_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !cart_visible |-> (!win_rd_en && !win_wr_en));

    p_overlay_off_r11: assert property (@(posedge clk) disable iff (rst)
        (ovl_acc && cart_visible) |=> (!overlay_on || nmi_req));

    p_freeze_sets_overlay_r11: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> overlay_on);

endmodule

bind fcart_freeze_ctrl fcart_freeze_sva #(
    .ADDR_W  (ADDR_W),
    .ROM_BASE(ROM_BASE)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_addr    (acc_addr),
    .bus_float   (bus_float),
    .rd_data     (rd_data),
    .win_rd_en   (win_rd_en),
    .win_wr_en   (win_wr_en),
    .nmi_req     (nmi_req),
    .cart_visible(cart_visible),
    .overlay_on  (overlay_on),
    .busy        (busy)
);

// File: tb/fcart_freeze_ctrl_tb.sv
module fcart_freeze_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  bus_float = 8'hA8;
    logic [7:0]  win_rdata = 8'h5C;
    logic        freeze_btn = 1'b0;
    logic [7:0]  rd_data;
    logic        win_rd_en, win_wr_en, nmi_req, cart_visible, overlay_on;

    always #10 clk = ~clk;

    fcart_freeze_ctrl u_dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .bus_float(bus_float), .win_rdata(win_rdata),
        .freeze_btn(freeze_btn), .rd_data(rd_data),
        .win_rd_en(win_rd_en), .win_wr_en(win_wr_en),
        .nmi_req(nmi_req), .cart_visible(cart_visible), .overlay_on(overlay_on)
    );

    typedef struct {
        string      req;
        logic       chk_rd;
        logic [7:0] rd;
        logic       nmi;
        logic       vis;
        logic       ovl;
    } exp_t;

    exp_t queue_exp[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle, after the driver has applied stimulus.
    always @(negedge clk) begin
        #2;
        while (queue_exp.size() > 0) begin
            exp_t e;
            e = queue_exp.pop_front();
            if (e.chk_rd) cmp(e.req, "rd_data", int'(rd_data), int'(e.rd));
            cmp(e.req, "nmi_req", int'(nmi_req), int'(e.nmi));
            cmp(e.req, "cart_visible", int'(cart_visible), int'(e.vis));
            cmp(e.req, "overlay_on", int'(overlay_on), int'(e.ovl));
        end
    end

    // Driver: applies one cycle of stimulus and pushes what must be seen in that cycle.
    task automatic step(input logic v, input logic w, input logic [23:0] a,
                        input logic [7:0] d, input logic b, input logic chk,
                        input logic [7:0] erd, input logic enmi, input logic evis,
                        input logic eovl, input string req);
        exp_t e;
        @(negedge clk);
        #1;
        acc_valid  = v;
        acc_write  = w;
        acc_addr   = a;
        acc_wdata  = d;
        freeze_btn = b;
        e.req = req; e.chk_rd = chk; e.rd = erd;
        e.nmi = enmi; e.vis = evis; e.ovl = eovl;
        queue_exp.push_back(e);
    endtask

    task automatic rd(input logic [23:0] a, input logic chk, input logic [7:0] erd,
                      input logic n, input logic vv, input logic o, input string req);
        step(1'b1, 1'b0, a, 8'h00, 1'b0, chk, erd, n, vv, o, req);
    endtask

    task automatic wr(input logic [23:0] a, input logic [7:0] d,
                      input logic n, input logic vv, input logic o, input string req);
        step(1'b1, 1'b1, a, d, 1'b0, 1'b0, 8'h00, n, vv, o, req);
    endtask

    task automatic idle(input logic b, input logic n, input logic vv, input logic o,
                        input string req);
        step(1'b0, 1'b0, 24'h0, 8'h00, b, 1'b0, 8'h00, n, vv, o, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, status hidden so the bus value comes back
        rd(24'h400001, 1, 8'hA8, 0, 0, 0, "R1");
        // R2: only a chip write ends the post-reset wait
        wr(24'hBFD100, 8'h00, 0, 0, 0, "R2");
        wr(24'h000100, 8'h00, 0, 0, 0, "R2");
        rd(24'h400001, 1, 8'hAB, 1, 1, 1, "R2");
        // R3: mirror, plain register byte, array data
        rd(24'h400003, 1, 8'hAB, 0, 1, 1, "R3_R9");
        rd(24'h400000, 1, 8'hA8, 0, 1, 1, "R3");
        rd(24'h400010, 1, 8'h5C, 0, 1, 1, "R3");
        // R11: overlay write
        wr(24'h400006, 8'h00, 0, 1, 1, "R11");
        idle(0, 0, 1, 0, "R11");
        // R4: arm read probe, hide
        wr(24'h400001, 8'h02, 0, 1, 0, "R4");
        rd(24'h400001, 1, 8'hA8, 0, 0, 0, "R4");
        // R5: wrong direction ignored, then read fires
        wr(24'hBFE001, 8'h00, 0, 0, 0, "R5");
        idle(0, 0, 0, 0, "R5");
        rd(24'hBFE001, 0, 8'h00, 0, 0, 0, "R5");
        rd(24'h400001, 1, 8'hA9, 1, 1, 1, "R5");
        // R9: in service, probe and button blocked
        rd(24'hBFE001, 0, 8'h00, 0, 1, 1, "R9");
        idle(1, 0, 1, 1, "R9");
        idle(1, 0, 1, 1, "R9");
        idle(1, 0, 1, 1, "R9");
        idle(0, 0, 1, 1, "R9");
        idle(0, 0, 1, 1, "R9");
        // R6: arm write probe through the mirror byte
        wr(24'h400003, 8'h01, 0, 1, 1, "R4_R6");
        rd(24'hBFD100, 0, 8'h00, 0, 0, 1, "R6");
        idle(0, 0, 0, 1, "R6");
        wr(24'hBFD100, 8'h00, 0, 0, 1, "R6");
        rd(24'h400001, 1, 8'hAA, 1, 1, 1, "R6");
        // R7 / R10: disarm, hidden control write dropped, probes idle
        wr(24'h400001, 8'h00, 0, 1, 1, "R7");
        wr(24'h400001, 8'h03, 0, 0, 1, "R10");
        rd(24'hBFE001, 0, 8'h00, 0, 0, 1, "R7_R10");
        wr(24'hBFD100, 8'h00, 0, 0, 1, "R7_R10");
        rd(24'h400001, 1, 8'hA8, 0, 0, 1, "R7_R10");
        // R8: button, request three cycles after the rise
        idle(1, 0, 0, 1, "R8");
        idle(1, 0, 0, 1, "R8");
        idle(1, 0, 0, 1, "R8");
        rd(24'h400001, 1, 8'hA8, 1, 1, 1, "R8");
        // R11: mirror overlay byte
        wr(24'h400007, 8'h00, 0, 1, 1, "R11");
        idle(0, 0, 1, 0, "R11");
        idle(0, 0, 1, 0, "R11");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule